// File: doc/BRIEF.md
# Wait-State Bus Bridge with Busy Timeout

This block carries single read and write requests from a host onto a 16-bit asynchronous peripheral port. The host raises a request and holds it until the bridge answers with a one-cycle ready pulse. The bridge then drives chip-select and either the read strobe or the write strobe. The strobe stays low for a programmed minimum number of wait states. After that it stays low for as long as the peripheral reports busy.

A timeout guard can be switched on. When it is on, it starts counting system clock cycles at the first busy cycle of an access. When the programmed count expires, it abandons the access: the host still gets ready, the read data is zero, and a one-cycle error pulse is raised.

Each request carries a class bit: memory access over the parallel port, or debug access. Each class has its own enable. A request whose class is disabled is answered at once, without touching the peripheral.

The configuration inputs are taken into the bridge when a request is accepted. A change to them during an access therefore does not affect that access.

Top module: `xbr_bridge`

## Requirements
- R1: During and right after reset, chip-select and both strobes are high (inactive), and ready and the timeout error are low.
- R2: With busy low throughout, an allowed access keeps chip-select and its strobe low for exactly W+1 cycles, where W is the wait-state count. Ready follows in the next cycle.
- R3: The strobe ends at the first strobe cycle whose index (counting from 0) is at least W and in which busy is low. Busy seen while the strobe is low therefore holds the strobe for the next cycle, unless the access is aborted.
- R4: With the timeout disabled, busy holds the strobe for as long as it lasts, and the access ends normally without an error.
- R5: With the timeout enabled and a count T, the access is aborted in the strobe cycle that is the T-th cycle counted from the first busy cycle (T of 0 acts as 1), if it has not completed normally by then. Normal completion in the same cycle takes priority.
- R6: An aborted access raises the timeout error for exactly one cycle, in the same cycle as ready, and returns zero read data.
- R7: During an access, the address and write data stay stable at the request's values. A request with the write bit 1 drives only the write strobe, and a request with the write bit 0 drives only the read strobe. A completed read returns the peripheral data sampled in the last strobe cycle, and a write returns zero.
- R8: A request with the class bit 0 (parallel-port memory) is allowed only when the parallel-port enable is 1. A request with the class bit 1 (debug) is allowed only when the debug enable is 1. A request that is not allowed gets ready in the cycle after it is accepted, with no chip-select, no strobe, zero read data and no error.
- R9: Ready is a single-cycle pulse, one per request, and chip-select is high whenever ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait | input | 7 | Minimum wait states per access |
| cfg_tmo_cnt | input | 12 | Timeout length in clock cycles |
| cfg_tmo_en | input | 1 | Timeout guard enable |
| cfg_pport_en | input | 1 | Allow parallel-port memory requests (tie to 1 by default) |
| cfg_dbg_en | input | 1 | Allow debug requests (tie to 0 by default) |
| req_valid | input | 1 | Host request, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_debug | input | 1 | Request class: 0 = parallel-port memory, 1 = debug |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with ready |
| tmo_err | output | 1 | One-cycle abort flag, coincident with ready |
| per_cs_n | output | 1 | Peripheral chip-select, active low |
| per_rd_n | output | 1 | Read strobe, active low |
| per_wr_n | output | 1 | Write strobe, active low |
| per_addr | output | ADDR_W | Peripheral address |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data |
| per_busy | input | 1 | Peripheral busy, extends the strobe |

## Verification
Wait-state counts are swept with busy held low, which isolates the base strobe width from any busy effect. Busy windows of varied start and length are then placed before, across and after the end of the wait-state count, with the guard off. This separates a wait-limited end from a busy-limited end, and a single very long busy window shows that nothing aborts while the guard is disabled. With the guard on, timeout lengths from 0 upward are crossed with the same windows. This tells apart aborts, late completions and the tie where both happen in one cycle. Every class and enable pairing is tried for reads and writes, to show that a refused request never strobes.

// File: rtl/xbr_pkg.sv
package xbr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_RESP   = 2'd2
    } xbr_state_e;

    localparam int unsigned NUM_CLASSES = 2;
    localparam int unsigned CLASS_PPORT = 0;
    localparam int unsigned CLASS_DEBUG = 1;
endpackage

// File: rtl/xbr_gate.sv
module xbr_gate #(
    parameter int unsigned CLASSES = 2,
    localparam int unsigned CLS_W = (CLASSES > 1) ? $clog2(CLASSES) : 1
) (
    input  logic [CLASSES-1:0] class_en,
    input  logic [CLS_W-1:0]   req_class,
    output logic               allowed
);
    logic [CLASSES-1:0] hit;

    for (genvar g = 0; g < CLASSES; g++) begin : g_cls
        assign hit[g] = class_en[g] && (req_class == CLS_W'(g));
    end

    assign allowed = |hit;
endmodule

// File: rtl/xbr_timer.sv
module xbr_timer #(
    parameter int unsigned WAIT_W = 7,
    parameter int unsigned TMO_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic              busy,
    input  logic              tmo_en,
    input  logic [WAIT_W-1:0] wait_lim,
    input  logic [TMO_W-1:0]  tmo_lim,
    output logic              wait_done,
    output logic              expire
);
    typedef struct packed {
        logic [WAIT_W-1:0] wcnt;
        logic [TMO_W-1:0]  tcnt;
        logic              seen;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic             armed;
    logic [TMO_W-1:0] lim_m1;

    always_comb begin
        tmr_d     = tmr_q;
        armed     = tmo_en && (busy || tmr_q.seen);
        lim_m1    = (tmo_lim == '0) ? '0 : tmo_lim - 1'b1;
        wait_done = (tmr_q.wcnt >= wait_lim);
        expire    = run && armed && (tmr_q.tcnt >= lim_m1);
        if (clear) begin
            tmr_d = '0;
        end else if (run) begin
            if (!wait_done) begin
                tmr_d.wcnt = tmr_q.wcnt + 1'b1;
            end
            if (busy) begin
                tmr_d.seen = 1'b1;
            end
            if (armed && (tmr_q.tcnt != '1)) begin
                tmr_d.tcnt = tmr_q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/xbr_bridge.sv
module xbr_bridge
    import xbr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WAIT_W = 7,
    parameter int unsigned TMO_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [TMO_W-1:0]  cfg_tmo_cnt,
    input  logic              cfg_tmo_en,
    input  logic              cfg_pport_en,
    input  logic              cfg_dbg_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_debug,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              tmo_err,
    output logic              per_cs_n,
    output logic              per_rd_n,
    output logic              per_wr_n,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              per_busy
);
    localparam int unsigned CLS_W = $clog2(NUM_CLASSES);

    typedef struct packed {
        xbr_state_e        st;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic [WAIT_W-1:0] wlim;
        logic [TMO_W-1:0]  tlim;
        logic              ten;
    } br_t;

    br_t  br_d, br_q;
    logic allowed;
    logic wait_done;
    logic expire;
    logic [NUM_CLASSES-1:0] cls_en;

    assign cls_en[CLASS_PPORT] = cfg_pport_en;
    assign cls_en[CLASS_DEBUG] = cfg_dbg_en;

    xbr_gate #(
        .CLASSES (NUM_CLASSES)
    ) i_gate (
        .class_en  (cls_en),
        .req_class (CLS_W'(req_debug)),
        .allowed   (allowed)
    );

    xbr_timer #(
        .WAIT_W (WAIT_W),
        .TMO_W  (TMO_W)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (br_q.st != ST_ACCESS),
        .run       (br_q.st == ST_ACCESS),
        .busy      (per_busy),
        .tmo_en    (br_q.ten),
        .wait_lim  (br_q.wlim),
        .tmo_lim   (br_q.tlim),
        .wait_done (wait_done),
        .expire    (expire)
    );

    always_comb begin
        br_d     = br_q;
        br_d.err = 1'b0;
        unique case (br_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    br_d.rdata = '0;
                    if (allowed) begin
                        br_d.st    = ST_ACCESS;
                        br_d.wr    = req_write;
                        br_d.addr  = req_addr;
                        br_d.wdata = req_wdata;
                        br_d.wlim  = cfg_wait;
                        br_d.tlim  = cfg_tmo_cnt;
                        br_d.ten   = cfg_tmo_en;
                    end else begin
                        br_d.st = ST_RESP;
                    end
                end
            end
            ST_ACCESS: begin
                if (wait_done && !per_busy) begin
                    br_d.st    = ST_RESP;
                    br_d.rdata = br_q.wr ? '0 : per_rdata;
                end else if (expire) begin
                    br_d.st    = ST_RESP;
                    br_d.rdata = '0;
                    br_d.err   = 1'b1;
                end
            end
            default: begin
                br_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            br_q <= '0;
        end else begin
            br_q <= br_d;
        end
    end

    assign req_ready = (br_q.st == ST_RESP);
    assign rsp_rdata = br_q.rdata;
    assign tmo_err   = br_q.err;
    assign per_cs_n  = (br_q.st != ST_ACCESS);
    assign per_rd_n  = !((br_q.st == ST_ACCESS) && !br_q.wr);
    assign per_wr_n  = !((br_q.st == ST_ACCESS) && br_q.wr);
    assign per_addr  = br_q.addr;
    assign per_wdata = br_q.wdata;
endmodule

// File: rtl/xbr_bridge_chk.sv
module xbr_bridge_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              tmo_err,
    input logic              per_cs_n,
    input logic              per_rd_n,
    input logic              per_wr_n,
    input logic [ADDR_W-1:0] per_addr,
    input logic [DATA_W-1:0] per_wdata,
    input logic              per_busy
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!per_rd_n && !per_wr_n)); // R7

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_rd_n || !per_wr_n) |-> !per_cs_n); // R9

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R9

    AST_READY_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> per_cs_n); // R8

    AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> (req_ready && (rsp_rdata == '0))); // R6

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |=> !tmo_err); // R6

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_cs_n && $past(!per_cs_n)) |-> ($stable(per_addr) && $stable(per_wdata))); // R7

    AST_BUSY_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_cs_n && per_busy) |=> (!per_cs_n || tmo_err)); // R3
endmodule

bind xbr_bridge xbr_bridge_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_xbr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_rdata (rsp_rdata),
    .tmo_err   (tmo_err),
    .per_cs_n  (per_cs_n),
    .per_rd_n  (per_rd_n),
    .per_wr_n  (per_wr_n),
    .per_addr  (per_addr),
    .per_wdata (per_wdata),
    .per_busy  (per_busy)
);

// File: tb/test_xbr_bridge.sv
`timescale 1ns/1ps
module test_xbr_bridge;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int WAIT_W = 7;
    localparam int TMO_W  = 12;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic [WAIT_W-1:0] cfg_wait;
    logic [TMO_W-1:0]  cfg_tmo_cnt;
    logic              cfg_tmo_en, cfg_pport_en, cfg_dbg_en;
    logic              req_valid, req_write, req_debug;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              req_ready, tmo_err;
    logic [DATA_W-1:0] rsp_rdata;
    logic              per_cs_n, per_rd_n, per_wr_n;
    logic [ADDR_W-1:0] per_addr;
    logic [DATA_W-1:0] per_wdata, per_rdata;
    logic              per_busy;

    xbr_bridge #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .WAIT_W (WAIT_W), .TMO_W (TMO_W)
    ) i_xbr_bridge (
        .clk (clk), .rst_n (rst_n),
        .cfg_wait (cfg_wait), .cfg_tmo_cnt (cfg_tmo_cnt), .cfg_tmo_en (cfg_tmo_en),
        .cfg_pport_en (cfg_pport_en), .cfg_dbg_en (cfg_dbg_en),
        .req_valid (req_valid), .req_write (req_write), .req_debug (req_debug),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .req_ready (req_ready), .rsp_rdata (rsp_rdata), .tmo_err (tmo_err),
        .per_cs_n (per_cs_n), .per_rd_n (per_rd_n), .per_wr_n (per_wr_n),
        .per_addr (per_addr), .per_wdata (per_wdata), .per_rdata (per_rdata),
        .per_busy (per_busy)
    );

    int checks = 0;
    int errors = 0;
    int txn_id = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // one request; peripheral busy is high in strobe cycles [b0, b0+bl)
    task automatic xfer(input bit wr, input bit dbg, input int w, input int t,
                        input bit ten, input int b0, input int bl, input string rq);
        int  k, sc, lat, errs, bad;
        bit  ab, allowed, got_ready;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] wd, pd, got;
        txn_id++;
        a  = ADDR_W'(txn_id * 37 + 5);
        wd = DATA_W'(txn_id * 4099 + 17);
        pd = DATA_W'(txn_id * 7919 + 3);
        allowed = dbg ? cfg_dbg_en : cfg_pport_en;
        k = 0; ab = 1'b0;
        if (allowed) begin
            for (int kk = 0; kk < 5000; kk++) begin
                bit bz;
                bz = (kk >= b0) && (kk < b0 + bl);
                if (kk >= w && !bz) begin k = kk; ab = 1'b0; break; end
                if (ten && bl > 0 && kk >= b0 && (kk - b0 + 1) >= ((t == 0) ? 1 : t)) begin
                    k = kk; ab = 1'b1; break;
                end
            end
        end
        sc = 0; lat = 0; errs = 0; bad = 0; got_ready = 1'b0; got = '0;
        @(negedge clk);
        cfg_wait    = WAIT_W'(w);
        cfg_tmo_cnt = TMO_W'(t);
        cfg_tmo_en  = ten;
        per_rdata   = pd;
        req_valid   = 1'b1;
        req_write   = wr;
        req_debug   = dbg;
        req_addr    = a;
        req_wdata   = wd;
        for (int i = 0; i < 3000 && !got_ready; i++) begin
            @(negedge clk);
            lat++;
            if (!per_cs_n) begin
                per_busy = (sc >= b0) && (sc < b0 + bl);
                if (wr ? (per_wr_n !== 1'b0 || per_rd_n !== 1'b1)
                       : (per_rd_n !== 1'b0 || per_wr_n !== 1'b1)) bad++;
                if (per_addr !== a || (wr && per_wdata !== wd)) bad++;
                sc++;
            end else begin
                per_busy = 1'b0;
            end
            if (tmo_err) errs++;
            if (req_ready) begin
                got_ready = 1'b1;
                got = rsp_rdata;
                req_valid = 1'b0;
            end
        end
        per_busy = 1'b0;
        if (allowed) begin
            chk(sc == k + 1, rq, sc, k + 1);
            chk(lat == k + 2, rq, lat, k + 2);
            chk(bad == 0, "R7", bad, 0);
            if (ab) chk(got == '0, "R6", int'(got), 0);
            else    chk(got == (wr ? '0 : pd), "R7", int'(got), wr ? 0 : int'(pd));
            chk(errs == int'(ab), ab ? "R6" : "R4", errs, int'(ab));
        end else begin
            chk(sc == 0, "R8", sc, 0);
            chk(lat == 1, "R8", lat, 1);
            chk(got == '0 && errs == 0, "R8", int'(got) + errs, 0);
        end
        @(negedge clk);
        chk(!req_ready && !tmo_err && per_cs_n, "R9",
            int'(req_ready) + int'(tmo_err), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_wait = '0; cfg_tmo_cnt = '0; cfg_tmo_en = 1'b0;
        cfg_pport_en = 1'b1; cfg_dbg_en = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_debug = 1'b0;
        req_addr = '0; req_wdata = '0; per_rdata = '0; per_busy = 1'b0;
        repeat (3) @(negedge clk);
        chk(per_cs_n && per_rd_n && per_wr_n && !req_ready && !tmo_err, "R1",
            int'({per_cs_n, per_rd_n, per_wr_n, req_ready, tmo_err}), 28);
        rst_n = 1'b1;
        @(negedge clk);
        chk(per_cs_n && per_rd_n && per_wr_n && !req_ready && !tmo_err, "R1",
            int'({per_cs_n, per_rd_n, per_wr_n, req_ready, tmo_err}), 28);

        // R2: base strobe width over wait counts
        for (int w = 0; w <= 8; w++) begin
            xfer(1'b0, 1'b0, w, 0, 1'b0, 0, 0, "R2");
            xfer(1'b1, 1'b0, w, 0, 1'b0, 0, 0, "R2");
        end
        xfer(1'b0, 1'b0, 40, 0, 1'b0, 0, 0, "R2");

        // R3: busy windows around the wait count, guard off
        for (int w = 0; w <= 4; w++)
            for (int b0 = 0; b0 <= 3; b0++)
                for (int bl = 1; bl <= 4; bl++)
                    xfer(1'(bl % 2), 1'b0, w, 0, 1'b0, b0, bl, "R3");

        // R4: long busy without guard, and guard longer than busy
        xfer(1'b0, 1'b0, 1, 0, 1'b0, 0, 60, "R4");
        xfer(1'b0, 1'b0, 1, 5, 1'b0, 0, 60, "R4");
        xfer(1'b1, 1'b0, 2, 100, 1'b1, 1, 30, "R4");

        // R5: guard lengths crossed with busy windows
        for (int w = 0; w <= 3; w++)
            for (int t = 0; t <= 5; t++)
                for (int b0 = 0; b0 <= 2; b0++)
                    for (int bl = 1; bl <= 9; bl++)
                        xfer(1'((t + bl) % 2), 1'b0, w, t, 1'b1, b0, bl, "R5");

        // R8: class gating under every enable pairing
        for (int pe = 0; pe <= 1; pe++)
            for (int de = 0; de <= 1; de++)
                for (int cl = 0; cl <= 1; cl++)
                    for (int wr = 0; wr <= 1; wr++) begin
                        cfg_pport_en = 1'(pe);
                        cfg_dbg_en   = 1'(de);
                        xfer(1'(wr), 1'(cl), 2, 3, 1'b1, 1, 2, "R8");
                    end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule